// File: doc/BRIEF.md
# Extra Compressed Byte/Halfword Load-Store Expander

This block sits in an instruction front end beside the standard compressed-instruction decompressor. Each cycle it may receive one 16-bit instruction halfword with a valid strobe. When its extension-enable input is high, it recognises eight additional 16-bit encodings. Four of them address memory through one of the registers x8–x15, and four address the stack pointer x2. Each encoding is an unsigned byte or halfword load or store. The block rewrites a recognised encoding as the equivalent 32-bit base-integer instruction.

The result is registered. One cycle after the strobe, the block presents the 32-bit word, an output valid and a hit flag. The hit flag is low for every halfword that is not one of the eight forms. In that case the word is zero, so the neighbouring decompressor can claim the halfword instead. When enable is low, nothing is recognised. This matters because these encodings overlap with other optional compressed sets.

Top module: `hw_ls_expander`

## Requirements
- R1: With enable high, a halfword with bits[15:13]=001 and bits[1:0]=00 expands to an unsigned byte load. The destination is x(8+bits[4:2]) and the base is x(8+bits[9:7]). The byte offset is bit12 + 2·bits[6:5] + 8·bits[11:10], giving a range of 0 to 31.
- R2: With enable high, bits[15:13]=101 and bits[1:0]=00 expands to a byte store. The registers and the offset are formed as in R1, with the data register taken from bits[4:2].
- R3: With enable high, bits[1:0]=10 with bits[15:13]=001 expands to an unsigned halfword load, and with bits[15:13]=101 to a halfword store. The offset is 2·bits[6:5] + 8·bits[12:10], an even value from 0 to 62.
- R4: With enable high, bits[15:11]=10000 and bits[1:0]=00 select a stack-relative form with base x2 and data register x(8+bits[4:2]). Bits[6:5] select the operation: 00 is byte load, 01 is halfword load, 10 is byte store and 11 is halfword store. For the byte forms the offset is bits[10:7], from 0 to 15.
- R5: For the stack-relative halfword forms, the offset is 2·bits[10:8] + 16·bit7, an even value from 0 to 30.
- R6: A load is emitted as offset[11:0] in [31:20], base in [19:15], funct3 in [14:12] (100 for byte, 101 for halfword), destination in [11:7] and opcode 0000011 in [6:0].
- R7: A store is emitted as offset[11:5] in [31:25], data register in [24:20], base in [19:15], funct3 in [14:12] (000 for byte, 001 for halfword), offset[4:0] in [11:7] and opcode 0100011 in [6:0].
- R8: When the enable input is low, the hit flag stays low and the word is zero for every halfword.
- R9: A halfword that matches none of the eight forms gives hit low and a word of zero.
- R10: The outputs appear one clock after the strobe. Output valid equals the input valid of the previous cycle. A cycle without a strobe gives valid low, hit low and a word of zero.
- R11: A synchronous active-high reset clears the output valid, the hit flag and the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe for in_half |
| in_half | input | 16 | Instruction halfword |
| ext_en | input | 1 | Enables recognition of the extra forms |
| out_valid | output | 1 | Registered copy of in_valid |
| out_word | output | 32 | Expanded 32-bit instruction, zero on no hit |
| out_hit | output | 1 | Halfword was one of the eight forms |

## Verification
Every output is due exactly one rising edge after the halfword is presented. The bench drives inputs on the falling edge and compares all three outputs on the following falling edge, after the single capturing edge. It compares them against a behavioural model evaluated on the inputs it has just driven. The reset checks are sampled on a falling edge while reset is held, and again on the falling edge after a reset that lands in the middle of traffic.

// File: rtl/hwx_pkg.sv
package hwx_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 32;
    localparam int REG_W    = 5;
    localparam int CREG_W   = 3;
    localparam int IMM_W    = 12;

    localparam logic [6:0]       OPC_LOAD  = 7'b0000011;
    localparam logic [6:0]       OPC_STORE = 7'b0100011;
    localparam logic [2:0]       F3_LBU    = 3'b100;
    localparam logic [2:0]       F3_LHU    = 3'b101;
    localparam logic [2:0]       F3_SB     = 3'b000;
    localparam logic [2:0]       F3_SH     = 3'b001;
    localparam logic [REG_W-1:0] STACK_REG = 5'd2;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_LDB,
        FORM_LDH,
        FORM_STB,
        FORM_STH
    } hwx_form_e;

    typedef struct packed {
        hwx_form_e          form;
        logic [REG_W-1:0]   base;
        logic [REG_W-1:0]   data;
        logic [IMM_W-1:0]   offset;
    } hwx_op_t;

    localparam hwx_op_t NONE_OP = '{form: FORM_NONE, base: '0, data: '0, offset: '0};

    // Short 3-bit register field -> x8..x15
    function automatic logic [REG_W-1:0] widen_reg(input logic [CREG_W-1:0] r);
        return {2'b01, r};
    endfunction

endpackage

// File: rtl/hwx_decode.sv
module hwx_decode
    import hwx_pkg::*;
#(
    parameter bit REG_FORMS = 1'b1,
    parameter bit SP_FORMS  = 1'b1
) (
    input  logic [HALF_W-1:0] half,
    input  logic              enable,
    output hwx_op_t           op
);

    hwx_op_t reg_op;
    hwx_op_t sp_op;

    generate
        if (REG_FORMS) begin : g_reg
            always_comb begin
                reg_op      = NONE_OP;
                reg_op.base = widen_reg(half[9:7]);
                reg_op.data = widen_reg(half[4:2]);
                unique case ({half[15:13], half[1:0]})
                    5'b001_00: begin
                        reg_op.form   = FORM_LDB;
                        reg_op.offset = {7'b0, half[11:10], half[6:5], half[12]};
                    end
                    5'b101_00: begin
                        reg_op.form   = FORM_STB;
                        reg_op.offset = {7'b0, half[11:10], half[6:5], half[12]};
                    end
                    5'b001_10: begin
                        reg_op.form   = FORM_LDH;
                        reg_op.offset = {6'b0, half[12:10], half[6:5], 1'b0};
                    end
                    5'b101_10: begin
                        reg_op.form   = FORM_STH;
                        reg_op.offset = {6'b0, half[12:10], half[6:5], 1'b0};
                    end
                    default: reg_op = NONE_OP;
                endcase
            end
        end else begin : g_no_reg
            assign reg_op = NONE_OP;
        end

        if (SP_FORMS) begin : g_sp
            always_comb begin
                sp_op = NONE_OP;
                if (half[15:11] == 5'b10000 && half[1:0] == 2'b00) begin
                    sp_op.base = STACK_REG;
                    sp_op.data = widen_reg(half[4:2]);
                    unique case (half[6:5])
                        2'b00: begin
                            sp_op.form   = FORM_LDB;
                            sp_op.offset = {8'b0, half[10:7]};
                        end
                        2'b01: begin
                            sp_op.form   = FORM_LDH;
                            sp_op.offset = {7'b0, half[7], half[10:8], 1'b0};
                        end
                        2'b10: begin
                            sp_op.form   = FORM_STB;
                            sp_op.offset = {8'b0, half[10:7]};
                        end
                        default: begin
                            sp_op.form   = FORM_STH;
                            sp_op.offset = {7'b0, half[7], half[10:8], 1'b0};
                        end
                    endcase
                end
            end
        end else begin : g_no_sp
            assign sp_op = NONE_OP;
        end
    endgenerate

    // The two families never overlap (bits[15:13] differ), so order is free.
    always_comb begin
        if (!enable)
            op = NONE_OP;
        else if (reg_op.form != FORM_NONE)
            op = reg_op;
        else
            op = sp_op;
    end

endmodule

// File: rtl/hwx_encode.sv
module hwx_encode
    import hwx_pkg::*;
(
    input  hwx_op_t           op,
    output logic [WORD_W-1:0] word,
    output logic              hit
);

    always_comb begin
        unique case (op.form)
            FORM_LDB: word = {op.offset, op.base, F3_LBU, op.data, OPC_LOAD};
            FORM_LDH: word = {op.offset, op.base, F3_LHU, op.data, OPC_LOAD};
            FORM_STB: word = {op.offset[11:5], op.data, op.base, F3_SB,
                              op.offset[4:0], OPC_STORE};
            FORM_STH: word = {op.offset[11:5], op.data, op.base, F3_SH,
                              op.offset[4:0], OPC_STORE};
            default:  word = '0;
        endcase
        hit = (op.form != FORM_NONE);
    end

endmodule

// File: rtl/hw_ls_expander.sv
module hw_ls_expander
    import hwx_pkg::*;
#(
    parameter bit REG_FORMS = 1'b1,
    parameter bit SP_FORMS  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_half,
    input  logic              ext_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_hit
);

    hwx_op_t           dec_op;
    logic [WORD_W-1:0] enc_word;
    logic              enc_hit;

    hwx_decode #(
        .REG_FORMS (REG_FORMS),
        .SP_FORMS  (SP_FORMS)
    ) u_decode (
        .half   (in_half),
        .enable (ext_en),
        .op     (dec_op)
    );

    hwx_encode u_encode (
        .op   (dec_op),
        .word (enc_word),
        .hit  (enc_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid & enc_hit;
            out_word  <= (in_valid && enc_hit) ? enc_word : '0;
        end
    end

endmodule

// File: rtl/hwx_checker.sv
module hwx_checker
    import hwx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [HALF_W-1:0] in_half,
    input logic              ext_en,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              out_hit
);

    // R10: valid follows the strobe by one cycle
    p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_hit && out_word == '0));

    // R8: disabled extension never hits
    p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !ext_en |=> !out_hit);

    // R9: a miss carries an all-zero word
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hit) |-> out_word == '0);

    // R6 / R7: a hit is always a base load or store with rd/rs2 in x8..x15
    p_opcode_r6: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_word[6:0] == OPC_LOAD || out_word[6:0] == OPC_STORE));
    p_load_dest_r6: assert property (@(posedge clk) disable iff (rst)
        (out_hit && out_word[6:0] == OPC_LOAD) |-> out_word[11:10] == 2'b01);
    p_store_src_r7: assert property (@(posedge clk) disable iff (rst)
        (out_hit && out_word[6:0] == OPC_STORE) |-> out_word[24:23] == 2'b01);

    // R11: reset clears the outputs
    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_hit && out_word == '0));

endmodule

bind hw_ls_expander hwx_checker u_hwx_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_half   (in_half),
    .ext_en    (ext_en),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_hit   (out_hit)
);

// File: tb/hw_ls_expander_bench.sv
module hw_ls_expander_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        ext_en = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hw_ls_expander u_hw_ls_expander (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_half   (in_half),
        .ext_en    (ext_en),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_hit   (out_hit)
    );

    // Behavioural reference: returns {hit, word}
    function automatic logic [32:0] model(input logic [15:0] h, input logic en);
        int unsigned op_kind;   // 0 none, 1 lbu, 2 lhu, 3 sb, 4 sh
        int unsigned base, data, off, w;
        op_kind = 0; base = 0; off = 0;
        data = 8 + h[4:2];
        if (en) begin
            if (h[1:0] == 2'b00 && h[15:13] == 3'b001) begin
                op_kind = 1; base = 8 + h[9:7];
                off = h[12] + 2 * h[6:5] + 8 * h[11:10];
            end else if (h[1:0] == 2'b00 && h[15:13] == 3'b101) begin
                op_kind = 3; base = 8 + h[9:7];
                off = h[12] + 2 * h[6:5] + 8 * h[11:10];
            end else if (h[1:0] == 2'b10 && h[15:13] == 3'b001) begin
                op_kind = 2; base = 8 + h[9:7];
                off = 2 * h[6:5] + 8 * h[12:10];
            end else if (h[1:0] == 2'b10 && h[15:13] == 3'b101) begin
                op_kind = 4; base = 8 + h[9:7];
                off = 2 * h[6:5] + 8 * h[12:10];
            end else if (h[1:0] == 2'b00 && h[15:11] == 5'b10000) begin
                base = 2;
                case (h[6:5])
                    2'b00: begin op_kind = 1; off = h[10:7]; end
                    2'b01: begin op_kind = 2; off = 2 * h[10:8] + 16 * h[7]; end
                    2'b10: begin op_kind = 3; off = h[10:7]; end
                    default: begin op_kind = 4; off = 2 * h[10:8] + 16 * h[7]; end
                endcase
            end
        end
        case (op_kind)
            1: w = off * (1 << 20) + base * (1 << 15) + 4 * (1 << 12) + data * (1 << 7) + 3;
            2: w = off * (1 << 20) + base * (1 << 15) + 5 * (1 << 12) + data * (1 << 7) + 3;
            3: w = (off / 32) * (1 << 25) + data * (1 << 20) + base * (1 << 15)
                   + (off % 32) * (1 << 7) + 35;
            4: w = (off / 32) * (1 << 25) + data * (1 << 20) + base * (1 << 15)
                   + 1 * (1 << 12) + (off % 32) * (1 << 7) + 35;
            default: w = 0;
        endcase
        return {op_kind != 0, w[31:0]};
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual hit=%0b word=%08h, expected hit=%0b word=%08h",
                     tag, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b, expected %0b", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic apply(input logic v, input logic [15:0] h, input logic e, input string tag);
        logic [32:0] exp;
        in_valid = v; in_half = h; ext_en = e;
        exp = v ? model(h, e) : 33'd0;
        @(negedge clk);
        check_bit({tag, " valid (R10)"}, out_valid, v);
        check(tag, {out_hit, out_word}, exp);
    endtask

    task automatic expect_word(input logic [15:0] h, input logic [31:0] w, input string tag);
        in_valid = 1'b1; in_half = h; ext_en = 1'b1;
        @(negedge clk);
        check(tag, {out_hit, out_word}, {1'b1, w});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11: reset state
        check_bit("R11 valid in reset", out_valid, 1'b0);
        check("R11 outputs in reset", {out_hit, out_word}, 33'd0);
        rst = 1'b0;

        // Known encodings with hand-computed words
        expect_word(16'h30C0, 32'h0054C403, "R1 lbu x8,5(x9)");
        expect_word(16'h3D60, 32'h01F54403, "R1 lbu x8,31(x10) max offset");
        expect_word(16'h24A2, 32'h00A4D403, "R3 lhu x8,10(x9)");
        expect_word(16'h8390, 32'h00714603, "R4 lbu x12,7(x2)");
        expect_word(16'h83D0, 32'h00C103A3, "R7 sb x12,7(x2)");

        // Register-form boundaries
        apply(1'b1, 16'hBD60, 1'b1, "R2 sb offset 31");
        apply(1'b1, 16'hA000, 1'b1, "R2 sb offset 0");
        apply(1'b1, 16'h3D62, 1'b1, "R3 lhu offset 62");
        apply(1'b1, 16'hBD62, 1'b1, "R3 sh offset 62 splits into high field");
        apply(1'b1, 16'hA002, 1'b1, "R3 sh offset 0");
        // Stack-relative boundaries
        apply(1'b1, 16'h879C, 1'b1, "R4 lbu sp offset 15");
        apply(1'b1, 16'h87DC, 1'b1, "R4 sb sp offset 15");
        apply(1'b1, 16'h87A0, 1'b1, "R5 lhu sp offset 30");
        apply(1'b1, 16'h87E0, 1'b1, "R5 sh sp offset 30");
        apply(1'b1, 16'h80A0, 1'b1, "R5 lhu sp offset 16");
        apply(1'b1, 16'h8020, 1'b1, "R6 lhu sp offset 0");
        // R8: enable low
        apply(1'b1, 16'h30C0, 1'b0, "R8 disabled register form");
        apply(1'b1, 16'h83D0, 1'b0, "R8 disabled stack form");
        apply(1'b1, 16'h24A2, 1'b0, "R8 disabled halfword form");
        // R9: non-matching halfwords
        apply(1'b1, 16'h0000, 1'b1, "R9 all zero");
        apply(1'b1, 16'h4000, 1'b1, "R9 other quadrant-0 major code");
        apply(1'b1, 16'h8800, 1'b1, "R9 bit11 set in stack prefix");
        apply(1'b1, 16'h30C1, 1'b1, "R9 quadrant 01");
        apply(1'b1, 16'h30C3, 1'b1, "R9 32-bit marker");
        apply(1'b1, 16'h9390, 1'b1, "R9 bit12 set in stack prefix");
        // R10: no strobe
        apply(1'b0, 16'h30C0, 1'b1, "R10 idle cycle");
        apply(1'b1, 16'h30C0, 1'b1, "R10 strobe after idle");

        // R11: mid-traffic reset
        in_valid = 1'b1; in_half = 16'h30C0; ext_en = 1'b1; rst = 1'b1;
        @(negedge clk);
        check_bit("R11 valid after reset", out_valid, 1'b0);
        check("R11 outputs after reset", {out_hit, out_word}, 33'd0);
        rst = 1'b0;

        // Mixed traffic against the model (R10 stream check)
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] h;
            h = 16'($urandom);
            case ($urandom % 4)
                0: h[1:0] = 2'b00;
                1: begin h[1:0] = 2'b00; h[15:11] = 5'b10000; end
                2: begin h[1:0] = 2'b10; h[14:13] = 2'b01; end
                default: ;
            endcase
            apply(($urandom % 5) != 0, h, ($urandom % 6) != 0, "R10 mixed stream");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule